// File: doc/BRIEF.md
# 2D Blit Parameter Register Front End

This block sits between a register write port and a 2D copy engine. Software programs source and destination coordinates, the rectangle size, and the pitch, base offset and tiling flag of each surface. Each of these can be written through its own register, or through packed alias registers that carry two fields in one word. The alias registers differ in which field sits in the low half and which in the high half. Every coordinate and size field is 14 bits wide.

The block holds the parameter set and drives it to the engine continuously. A write that carries a width value starts an operation: in the next cycle the block raises `start` for one cycle, and the parameter outputs already show the values from that write. A write that sets only a height, an X or a Y updates the stored values and starts nothing. While the engine reports `busy`, the block drops every write, so the parameters cannot change under a running operation.

Top module: `blt_param_frontend`

## Requirements
- R1: After reset every parameter output is zero and `start` is low.
- R2: The single-field select codes are 0 (source X), 1 (source Y), 2 (destination X), 3 (destination Y), 4 (width) and 5 (height). Each keeps only `wr_data[13:0]` and drops the higher bits.
- R3: The packed coordinate codes are as follows. Code 6 (source) and code 8 (destination) take X from `[13:0]` and Y from `[29:16]`. Code 7 (source) and code 9 (destination) take Y from `[13:0]` and X from `[29:16]`.
- R4: Code 10 takes width from `[13:0]` and height from `[29:16]`. Code 11 takes height from `[13:0]` and width from `[29:16]`.
- R5: Code 12 takes destination X from `[13:0]` and width from `[29:16]`. Code 13 takes destination Y from `[13:0]` and height from `[29:16]`.
- R6: An accepted write to code 4, 10, 11 or 12 raises `start` for exactly the next cycle. In that cycle the outputs already hold the values from that write. Writes on back-to-back cycles give back-to-back pulses.
- R7: An accepted write to any other code leaves `start` low.
- R8: Code 14 (source) and code 15 (destination) load the surface from a packed word. The offset becomes `[20:0]` shifted left by 5, the pitch becomes `[30:21]`, and the tile flag becomes bit 31.
- R9: Code 16 (source) and code 17 (destination) load the offset directly, with bits `[3:0]` forced to zero.
- R10: Code 18 (source) and code 19 (destination) load the pitch from `[13:0]` and the tile flag from bit 16.
- R11: While `busy` is high, a write changes no output and raises no `start`.
- R12: A write to any code above 19 changes no output and raises no `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select code |
| wr_data | input | 32 | Write data |
| busy | input | 1 | Engine busy; writes are dropped while high |
| start | output | 1 | One-cycle operation launch |
| src_x | output | 14 | Source X |
| src_y | output | 14 | Source Y |
| dst_x | output | 14 | Destination X |
| dst_y | output | 14 | Destination Y |
| width | output | 14 | Rectangle width |
| height | output | 14 | Rectangle height |
| src_pitch | output | 14 | Source pitch |
| dst_pitch | output | 14 | Destination pitch |
| src_offset | output | 32 | Source base offset |
| dst_offset | output | 32 | Destination base offset |
| src_tile | output | 1 | Source tiling flag |
| dst_tile | output | 1 | Destination tiling flag |

## Verification
The bench builds the block with its default parameters: 14-bit coordinates, high fields starting at bit 16, a 21-bit packed offset shifted by 5, a 10-bit packed pitch and 16-byte offset alignment. With these values, write data that sets bits 14, 15, 30 and 31 shows whether masking drops those bits. The same values make the packed pitch-offset split fall on the bit boundaries that the requirements name. The stimulus also sends writes while `busy` is high, back-to-back width writes and undecoded select codes, so the launch rules are exercised at their edges.

// File: rtl/blt_fe_pkg.sv
`timescale 1ns/1ps
package blt_fe_pkg;

   localparam int unsigned SEL_W   = 5;
   localparam int unsigned N_COORD = 6;
   localparam int unsigned N_SURF  = 2;

   // coordinate slot indices
   localparam int unsigned CI_SRC_X  = 0;
   localparam int unsigned CI_SRC_Y  = 1;
   localparam int unsigned CI_DST_X  = 2;
   localparam int unsigned CI_DST_Y  = 3;
   localparam int unsigned CI_WIDTH  = 4;
   localparam int unsigned CI_HEIGHT = 5;

   typedef enum logic [SEL_W-1:0] {
      SEL_SRC_X     = 5'd0,
      SEL_SRC_Y     = 5'd1,
      SEL_DST_X     = 5'd2,
      SEL_DST_Y     = 5'd3,
      SEL_WIDTH     = 5'd4,
      SEL_HEIGHT    = 5'd5,
      SEL_SRC_YX    = 5'd6,
      SEL_SRC_XY    = 5'd7,
      SEL_DST_YX    = 5'd8,
      SEL_DST_XY    = 5'd9,
      SEL_HGT_WID   = 5'd10,
      SEL_WID_HGT   = 5'd11,
      SEL_WID_X     = 5'd12,
      SEL_HGT_Y     = 5'd13,
      SEL_SRC_PO    = 5'd14,
      SEL_DST_PO    = 5'd15,
      SEL_SRC_OFFS  = 5'd16,
      SEL_DST_OFFS  = 5'd17,
      SEL_SRC_PITCH = 5'd18,
      SEL_DST_PITCH = 5'd19
   } blt_sel_e;

   function automatic blt_sel_e surf_po_sel(input int unsigned s);
      return (s == 0) ? SEL_SRC_PO : SEL_DST_PO;
   endfunction

   function automatic blt_sel_e surf_offs_sel(input int unsigned s);
      return (s == 0) ? SEL_SRC_OFFS : SEL_DST_OFFS;
   endfunction

   function automatic blt_sel_e surf_pitch_sel(input int unsigned s);
      return (s == 0) ? SEL_SRC_PITCH : SEL_DST_PITCH;
   endfunction

endpackage

// File: rtl/blt_coord_dec.sv
`timescale 1ns/1ps
module blt_coord_dec
   import blt_fe_pkg::*;
(
   input  logic               we,
   input  logic [SEL_W-1:0]   sel,
   output logic [N_COORD-1:0] upd,
   output logic [N_COORD-1:0] use_hi,
   output logic               launch
);

   logic [N_COORD-1:0] hit;

   always_comb begin
      hit    = '0;
      use_hi = '0;
      case (sel)
         SEL_SRC_X:  hit[CI_SRC_X]  = 1'b1;
         SEL_SRC_Y:  hit[CI_SRC_Y]  = 1'b1;
         SEL_DST_X:  hit[CI_DST_X]  = 1'b1;
         SEL_DST_Y:  hit[CI_DST_Y]  = 1'b1;
         SEL_WIDTH:  hit[CI_WIDTH]  = 1'b1;
         SEL_HEIGHT: hit[CI_HEIGHT] = 1'b1;
         SEL_SRC_YX: begin
            hit[CI_SRC_X]    = 1'b1;
            hit[CI_SRC_Y]    = 1'b1;
            use_hi[CI_SRC_Y] = 1'b1;
         end
         SEL_SRC_XY: begin
            hit[CI_SRC_X]    = 1'b1;
            hit[CI_SRC_Y]    = 1'b1;
            use_hi[CI_SRC_X] = 1'b1;
         end
         SEL_DST_YX: begin
            hit[CI_DST_X]    = 1'b1;
            hit[CI_DST_Y]    = 1'b1;
            use_hi[CI_DST_Y] = 1'b1;
         end
         SEL_DST_XY: begin
            hit[CI_DST_X]    = 1'b1;
            hit[CI_DST_Y]    = 1'b1;
            use_hi[CI_DST_X] = 1'b1;
         end
         SEL_HGT_WID: begin
            hit[CI_WIDTH]     = 1'b1;
            hit[CI_HEIGHT]    = 1'b1;
            use_hi[CI_HEIGHT] = 1'b1;
         end
         SEL_WID_HGT: begin
            hit[CI_WIDTH]    = 1'b1;
            hit[CI_HEIGHT]   = 1'b1;
            use_hi[CI_WIDTH] = 1'b1;
         end
         SEL_WID_X: begin
            hit[CI_DST_X]    = 1'b1;
            hit[CI_WIDTH]    = 1'b1;
            use_hi[CI_WIDTH] = 1'b1;
         end
         SEL_HGT_Y: begin
            hit[CI_DST_Y]     = 1'b1;
            hit[CI_HEIGHT]    = 1'b1;
            use_hi[CI_HEIGHT] = 1'b1;
         end
         default: hit = '0;
      endcase
   end

   // any accepted write carrying a width value launches an operation
   assign upd    = we ? hit : '0;
   assign launch = upd[CI_WIDTH];

endmodule

// File: rtl/blt_surf_regs.sv
`timescale 1ns/1ps
module blt_surf_regs #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PITCH_W    = 14,
   parameter int unsigned PK_OFFS_W  = 21,
   parameter int unsigned PK_PITCH_W = 10,
   parameter int unsigned PK_SHIFT   = 5,
   parameter int unsigned ALIGN_W    = 4,
   parameter int unsigned TILE_BIT   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_pk,
   input  logic              we_offs,
   input  logic              we_pitch,
   input  logic [DATA_W-1:0] data,
   output logic [PITCH_W-1:0] pitch,
   output logic [DATA_W-1:0] offset,
   output logic              tile
);

   localparam int unsigned PK_PITCH_LSB = PK_OFFS_W;
   localparam int unsigned PK_TILE_BIT  = DATA_W - 1;

   logic [DATA_W-1:0]  pk_offs;
   logic [PITCH_W-1:0] pk_pitch;
   logic [DATA_W-1:0]  dir_offs;

   assign pk_offs  = DATA_W'(data[PK_OFFS_W-1:0]) << PK_SHIFT;
   assign pk_pitch = PITCH_W'(data[PK_PITCH_LSB +: PK_PITCH_W]);
   assign dir_offs = {data[DATA_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pitch  <= '0;
         offset <= '0;
         tile   <= 1'b0;
      end else if (we_pk) begin
         offset <= pk_offs;
         pitch  <= pk_pitch;
         tile   <= data[PK_TILE_BIT];
      end else begin
         if (we_offs) begin
            offset <= dir_offs;
         end
         if (we_pitch) begin
            pitch <= data[PITCH_W-1:0];
            tile  <= data[TILE_BIT];
         end
      end
   end

endmodule

// File: rtl/blt_launch.sv
`timescale 1ns/1ps
module blt_launch (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start <= 1'b0;
      end else begin
         start <= fire;
      end
   end

endmodule

// File: rtl/blt_param_frontend.sv
`timescale 1ns/1ps
module blt_param_frontend
   import blt_fe_pkg::*;
#(
   parameter int unsigned COORD_W    = 14,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned HI_LSB     = 16,
   parameter int unsigned PITCH_W    = 14,
   parameter int unsigned PK_OFFS_W  = 21,
   parameter int unsigned PK_PITCH_W = 10,
   parameter int unsigned PK_SHIFT   = 5,
   parameter int unsigned ALIGN_W    = 4,
   parameter int unsigned TILE_BIT   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   wr_sel,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               busy,
   output logic               start,
   output logic [COORD_W-1:0] src_x,
   output logic [COORD_W-1:0] src_y,
   output logic [COORD_W-1:0] dst_x,
   output logic [COORD_W-1:0] dst_y,
   output logic [COORD_W-1:0] width,
   output logic [COORD_W-1:0] height,
   output logic [PITCH_W-1:0] src_pitch,
   output logic [PITCH_W-1:0] dst_pitch,
   output logic [DATA_W-1:0]  src_offset,
   output logic [DATA_W-1:0]  dst_offset,
   output logic               src_tile,
   output logic               dst_tile
);

   localparam int unsigned HI_TOP = HI_LSB + COORD_W;

   // elaboration-time parameter checks
   if (COORD_W < 1 || COORD_W > HI_LSB) begin : g_bad_coord
      $error("COORD_W must be between 1 and HI_LSB");
   end
   if (HI_TOP > DATA_W) begin : g_bad_hi
      $error("high coordinate field exceeds the data word");
   end
   if (PK_OFFS_W + PK_PITCH_W + 1 != DATA_W) begin : g_bad_pack
      $error("packed offset, pitch and tile must fill the data word");
   end
   if (PITCH_W <= PK_PITCH_W || PITCH_W > DATA_W) begin : g_bad_pitch
      $error("PITCH_W must exceed the packed pitch width");
   end
   if (ALIGN_W < 1 || ALIGN_W >= DATA_W || TILE_BIT >= DATA_W) begin : g_bad_misc
      $error("ALIGN_W or TILE_BIT out of range");
   end

   logic               accept;
   logic [N_COORD-1:0] upd;
   logic [N_COORD-1:0] use_hi;
   logic               launch;
   logic [COORD_W-1:0] lo_val;
   logic [COORD_W-1:0] hi_val;
   logic [COORD_W-1:0] coord_q [N_COORD];
   logic [PITCH_W-1:0] pitch_a [N_SURF];
   logic [DATA_W-1:0]  offs_a  [N_SURF];
   logic               tile_a  [N_SURF];

   assign accept = wr_en & ~busy;
   assign lo_val = wr_data[COORD_W-1:0];
   assign hi_val = wr_data[HI_LSB +: COORD_W];

   blt_coord_dec u_dec (
      .we     (accept),
      .sel    (wr_sel),
      .upd    (upd),
      .use_hi (use_hi),
      .launch (launch)
   );

   for (genvar i = 0; i < N_COORD; i++) begin : g_coord
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            coord_q[i] <= '0;
         end else if (upd[i]) begin
            coord_q[i] <= use_hi[i] ? hi_val : lo_val;
         end
      end
   end

   for (genvar s = 0; s < N_SURF; s++) begin : g_surf
      blt_surf_regs #(
         .DATA_W     (DATA_W),
         .PITCH_W    (PITCH_W),
         .PK_OFFS_W  (PK_OFFS_W),
         .PK_PITCH_W (PK_PITCH_W),
         .PK_SHIFT   (PK_SHIFT),
         .ALIGN_W    (ALIGN_W),
         .TILE_BIT   (TILE_BIT)
      ) u_surf (
         .clk      (clk),
         .rst_n    (rst_n),
         .we_pk    (accept && (wr_sel == surf_po_sel(s))),
         .we_offs  (accept && (wr_sel == surf_offs_sel(s))),
         .we_pitch (accept && (wr_sel == surf_pitch_sel(s))),
         .data     (wr_data),
         .pitch    (pitch_a[s]),
         .offset   (offs_a[s]),
         .tile     (tile_a[s])
      );
   end

   blt_launch u_launch (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (launch),
      .start (start)
   );

   assign src_x      = coord_q[CI_SRC_X];
   assign src_y      = coord_q[CI_SRC_Y];
   assign dst_x      = coord_q[CI_DST_X];
   assign dst_y      = coord_q[CI_DST_Y];
   assign width      = coord_q[CI_WIDTH];
   assign height     = coord_q[CI_HEIGHT];
   assign src_pitch  = pitch_a[0];
   assign dst_pitch  = pitch_a[1];
   assign src_offset = offs_a[0];
   assign dst_offset = offs_a[1];
   assign src_tile   = tile_a[0];
   assign dst_tile   = tile_a[1];

endmodule

// File: rtl/blt_param_frontend_chk.sv
`timescale 1ns/1ps
module blt_param_frontend_chk
   import blt_fe_pkg::*;
#(
   parameter int unsigned COORD_W = 14,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PITCH_W = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [SEL_W-1:0]   wr_sel,
   input logic               busy,
   input logic               start,
   input logic [COORD_W-1:0] src_x,
   input logic [COORD_W-1:0] src_y,
   input logic [COORD_W-1:0] dst_x,
   input logic [COORD_W-1:0] dst_y,
   input logic [COORD_W-1:0] width,
   input logic [COORD_W-1:0] height,
   input logic [PITCH_W-1:0] src_pitch,
   input logic [PITCH_W-1:0] dst_pitch,
   input logic [DATA_W-1:0]  src_offset,
   input logic [DATA_W-1:0]  dst_offset,
   input logic               src_tile,
   input logic               dst_tile
);

   logic wid_write;
   logic all_stable_next;

   assign wid_write = wr_en && !busy &&
                      (wr_sel inside {SEL_WIDTH, SEL_HGT_WID, SEL_WID_HGT, SEL_WID_X});

   AST_WIDTH_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      wid_write |=> start);  // R6

   AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(wid_write));  // R6

   AST_OTHER_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(wr_sel inside {SEL_WIDTH, SEL_HGT_WID, SEL_WID_HGT, SEL_WID_X})) |=> !start);  // R7

   AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !start);  // R11

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(src_x) && $stable(src_y) && $stable(dst_x) && $stable(dst_y) &&
                $stable(width) && $stable(height) && $stable(src_pitch) &&
                $stable(dst_pitch) && $stable(src_offset) && $stable(dst_offset) &&
                $stable(src_tile) && $stable(dst_tile)));  // R11

   AST_UNDECODED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel > SEL_DST_PITCH)) |=>
         ($stable(src_x) && $stable(src_y) && $stable(dst_x) && $stable(dst_y) &&
          $stable(width) && $stable(height) && $stable(src_pitch) &&
          $stable(dst_pitch) && $stable(src_offset) && $stable(dst_offset) &&
          $stable(src_tile) && $stable(dst_tile) && !start));  // R12

   assign all_stable_next = 1'b1;

   always @(posedge clk) begin
      if (rst_n && all_stable_next) begin
         AST_OFFSET_ALIGNED: assert (src_offset[3:0] == 4'h0 && dst_offset[3:0] == 4'h0);  // R9
      end
   end

endmodule

bind blt_param_frontend blt_param_frontend_chk #(
   .COORD_W (COORD_W),
   .DATA_W  (DATA_W),
   .PITCH_W (PITCH_W)
) u_chk (.*);

// File: tb/tb_blt_param_frontend.sv
`timescale 1ns/1ps
module tb_blt_param_frontend;
   import blt_fe_pkg::*;

   localparam int CW = 14;
   localparam int DW = 32;
   localparam int PW = 14;
   localparam int VW = 1 + 6*CW + 2*PW + 2*DW + 2;
   localparam int MAX_CYC = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic          start;
   logic [CW-1:0] src_x, src_y, dst_x, dst_y, width, height;
   logic [PW-1:0] src_pitch, dst_pitch;
   logic [DW-1:0] src_offset, dst_offset;
   logic          src_tile, dst_tile;

   always #2 clk = ~clk;

   blt_param_frontend dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .busy(busy), .start(start), .src_x(src_x), .src_y(src_y), .dst_x(dst_x),
      .dst_y(dst_y), .width(width), .height(height), .src_pitch(src_pitch),
      .dst_pitch(dst_pitch), .src_offset(src_offset), .dst_offset(dst_offset),
      .src_tile(src_tile), .dst_tile(dst_tile)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // scoreboard queues
   logic [VW-1:0] q_exp[$];
   int            q_due[$];
   string         q_req[$];

   // reference model state
   logic [CW-1:0] m_sx = '0, m_sy = '0, m_dx = '0, m_dy = '0, m_w = '0, m_h = '0;
   logic [PW-1:0] m_sp = '0, m_dp = '0;
   logic [DW-1:0] m_so = '0, m_do = '0;
   logic          m_st = 1'b0, m_dt = 1'b0;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   wire [VW-1:0] act = {start, src_x, src_y, dst_x, dst_y, width, height,
                        src_pitch, dst_pitch, src_offset, dst_offset, src_tile, dst_tile};

   // monitor: compare each expected item in the cycle it falls due
   always @(negedge clk) begin
      while (q_due.size() > 0 && q_due[0] == cyc) begin
         logic [VW-1:0] e;
         string r;
         e = q_exp.pop_front();
         r = q_req.pop_front();
         void'(q_due.pop_front());
         checks++;
         if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", r, act, e);
         end
      end
   end

   // driver: one write (or idle) per cycle, expected result pushed for the next cycle
   task automatic step(input bit we, input logic [4:0] sel, input logic [DW-1:0] d,
                       input bit bz, input string req);
      bit fire;
      @(negedge clk);
      wr_en   = we;
      wr_sel  = sel;
      wr_data = d;
      busy    = bz;
      fire    = 1'b0;
      if (we && !bz) begin
         case (sel)
            5'd0:  m_sx = d[13:0];
            5'd1:  m_sy = d[13:0];
            5'd2:  m_dx = d[13:0];
            5'd3:  m_dy = d[13:0];
            5'd4:  begin m_w = d[13:0]; fire = 1'b1; end
            5'd5:  m_h = d[13:0];
            5'd6:  begin m_sx = d[13:0];  m_sy = d[29:16]; end
            5'd7:  begin m_sy = d[13:0];  m_sx = d[29:16]; end
            5'd8:  begin m_dx = d[13:0];  m_dy = d[29:16]; end
            5'd9:  begin m_dy = d[13:0];  m_dx = d[29:16]; end
            5'd10: begin m_w = d[13:0];   m_h = d[29:16]; fire = 1'b1; end
            5'd11: begin m_h = d[13:0];   m_w = d[29:16]; fire = 1'b1; end
            5'd12: begin m_dx = d[13:0];  m_w = d[29:16]; fire = 1'b1; end
            5'd13: begin m_dy = d[13:0];  m_h = d[29:16]; end
            5'd14: begin m_so = {6'b0, d[20:0], 5'b0}; m_sp = {4'b0, d[30:21]}; m_st = d[31]; end
            5'd15: begin m_do = {6'b0, d[20:0], 5'b0}; m_dp = {4'b0, d[30:21]}; m_dt = d[31]; end
            5'd16: m_so = d & 32'hFFFF_FFF0;
            5'd17: m_do = d & 32'hFFFF_FFF0;
            5'd18: begin m_sp = d[13:0]; m_st = d[16]; end
            5'd19: begin m_dp = d[13:0]; m_dt = d[16]; end
            default: ;
         endcase
      end
      q_exp.push_back({fire, m_sx, m_sy, m_dx, m_dy, m_w, m_h,
                       m_sp, m_dp, m_so, m_do, m_st, m_dt});
      q_due.push_back(cyc + 1);
      q_req.push_back(req);
   endtask

   task automatic idle(input string req);
      step(1'b0, 5'd0, '0, 1'b0, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R1");                                   // reset state
      idle("R1");
      // R2: single-field registers drop bits above 13
      step(1, 5'd0, 32'hFFFF_C123, 0, "R2");
      step(1, 5'd1, 32'h0001_7FFF, 0, "R2");
      step(1, 5'd2, 32'h0000_4ABC, 0, "R2");
      step(1, 5'd3, 32'h0001_2345, 0, "R2");
      step(1, 5'd5, 32'hFFFF_FFFF, 0, "R7");        // height alone: no start
      // R3: packed coordinate pairs, both orders, both surfaces
      step(1, 5'd6, 32'hD234_C567, 0, "R3");
      step(1, 5'd7, 32'h0ABC_0DEF, 0, "R3");
      step(1, 5'd8, 32'h4111_8222, 0, "R3");
      step(1, 5'd9, 32'h0333_0444, 0, "R3");
      // R4: height-width pairs, each launches
      step(1, 5'd10, 32'h0020_0010, 0, "R4");
      idle("R6");
      step(1, 5'd11, 32'hC030_4040, 0, "R4");
      idle("R6");
      // R5: width-X launches, height-Y does not
      step(1, 5'd12, 32'h0050_0007, 0, "R5");
      step(1, 5'd13, 32'h0060_0009, 0, "R5");
      // R6: direct width, back-to-back launches
      step(1, 5'd4, 32'h0000_FFFF, 0, "R6");
      step(1, 5'd4, 32'h0000_0005, 0, "R6");
      step(1, 5'd4, 32'h0000_0006, 0, "R6");
      idle("R6");
      // R7: coordinate-only writes never launch
      step(1, 5'd0, 32'h0000_0001, 0, "R7");
      step(1, 5'd3, 32'h0000_0002, 0, "R7");
      step(1, 5'd18, 32'h0000_0100, 0, "R7");
      // R8: packed pitch-offset for both surfaces
      step(1, 5'd14, 32'hABCD_1234, 0, "R8");
      step(1, 5'd15, 32'h7FFF_FFFF, 0, "R8");
      step(1, 5'd15, 32'h8020_0001, 0, "R8");
      // R9: direct offsets keep 16-byte alignment
      step(1, 5'd16, 32'h1234_567F, 0, "R9");
      step(1, 5'd17, 32'hFFFF_FFFF, 0, "R9");
      // R10: direct pitch with tile bit 16
      step(1, 5'd18, 32'h0001_FFFF, 0, "R10");
      step(1, 5'd19, 32'hFFFE_C0DE, 0, "R10");
      step(1, 5'd19, 32'h0001_0100, 0, "R10");
      // R11: every write dropped while busy
      step(1, 5'd4,  32'h0000_1111, 1, "R11");
      step(1, 5'd10, 32'h2222_3333, 1, "R11");
      step(1, 5'd14, 32'h1234_5678, 1, "R11");
      step(1, 5'd0,  32'h0000_0ABC, 1, "R11");
      idle("R11");
      // R12: undecoded select codes
      step(1, 5'd20, 32'hFFFF_FFFF, 0, "R12");
      step(1, 5'd31, 32'h1234_5678, 0, "R12");
      idle("R12");
      // final launch after the busy window: values from before plus new width
      step(1, 5'd12, 32'h0123_0045, 0, "R6");
      idle("R6");
      while (q_due.size() > 0) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule